// File: doc/BRIEF.md
# SIMD Widening Left-Shift Unit

This block executes one vector instruction: it takes a 64-bit source operand, splits it into narrow lanes of 8, 16 or 32 bits, extends every lane to twice its width (with sign or zeros), and shifts each widened lane left by an immediate amount. The result is 128 bits, meant for an even/odd pair of 64-bit destination registers. With a shift of zero the operation is a plain widening move.

The unit receives the raw 32-bit instruction word, the source value and a flag that says whether the upper half of the register bank is implemented. It decodes the word itself. It reports whether the word belongs to this operation, whether the encoding is undefined, the destination register index, and a write enable. All outputs are registered once, so a request presented at one rising edge appears at the output after that edge. Register file access and pipeline control are left to the surrounding logic.

Top module: `vws_widen_shl`

## Requirements
- R1: A word is matched only when bits [31:25] are 1111001, bit 23 is 1, bits [11:8] are 1010, bit 7 is 0, bit 4 is 1 and bits [21:19] are not all zero. For any other word `out_match`, `out_undef` and `out_wr_en` are all 0.
- R2: A word whose bits [21:19] are 000 is not matched, even if all the fixed bits are correct.
- R3: The lane size and the shift come from the leading one of bits [21:19]. If bit 21 is 1, lanes are 32 bits and the shift is bits [20:16]. If [21:20] is 01, lanes are 16 bits and the shift is bits [19:16]. If [21:19] is 001, lanes are 8 bits and the shift is bits [18:16].
- R4: Bit 24 at 1 zero-extends each lane. Bit 24 at 0 sign-extends each lane.
- R5: A shift of zero gives the extended lane values with no shifting.
- R6: Each widened lane holds only its own shifted value. Its low `shift` bits are zero, and no bit of a neighbouring lane appears in it.
- R7: Source lane k (counted from bit 0 upward) lands in result lane k. So the low 32 bits of the source fill result bits [63:0], and the high 32 bits fill result bits [127:64].
- R8: A matched word whose destination index is odd is flagged undefined.
- R9: When `hi_bank_present` is 0, a matched word is flagged undefined if bit 4 of either the destination index or the source index is 1. When `hi_bank_present` is 1, such indices are legal.
- R10: The destination index is {bit 22, bits [15:12]}. The source index is {bit 5, bits [3:0]}. `out_wr_en` is 1 exactly when the output is valid, the word is matched and it is not undefined.
- R11: Outputs are registered one cycle after the input. `out_valid` follows `in_valid` by one cycle. A synchronous active-low reset clears `out_valid`, `out_match`, `out_undef` and `out_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operand present this cycle |
| insn | input | 32 | Raw instruction word |
| src | input | 64 | Source vector operand |
| hi_bank_present | input | 1 | Upper 16 registers of the bank exist |
| out_valid | output | 1 | Result registers hold a processed request |
| out_match | output | 1 | Word belongs to this operation |
| out_undef | output | 1 | Matched word has an undefined encoding |
| out_wr_en | output | 1 | Write the result to the register pair |
| out_dst | output | 5 | Even destination register index |
| out_result | output | 128 | Widened and shifted vector |

## Verification
The bench sets every source lane to all ones and uses the largest legal shift for each lane size. An unmasked or shift-then-widen design would then leak bits into the next lane or lose the sign copies. Unsigned and signed forms of the same word expose an extender that ignores bit 24. Encodings with 000 in the size field, a broken fixed bit, an odd destination, and upper-bank indices with and without the bank show whether the decode flags and the write enable are gated correctly. Idle gaps between requests catch a valid flag that does not track the input.

// File: rtl/vws_pkg.sv
// Shared types for the widening left-shift unit.
// Assumes a 64-bit source vector and 5-bit register indices.
package vws_pkg;
    localparam int SRC_W = 64;
    localparam int RES_W = 2 * SRC_W;
    localparam int IDX_W = 5;
    localparam int SH_W  = 5;

    typedef enum logic [1:0] {
        LANE_B = 2'd0,
        LANE_H = 2'd1,
        LANE_W = 2'd2
    } lane_sz_e;

    typedef struct packed {
        logic             hit;
        logic             is_uns;
        lane_sz_e         sz;
        logic [SH_W-1:0]  sh;
        logic [IDX_W-1:0] vd;
        logic [IDX_W-1:0] vm;
    } dec_t;
endpackage

// File: rtl/vws_lane.sv
// One lane: extends an element of LW bits to 2*LW bits, then shifts it left.
// Assumes the shift is below LW, so nothing leaves the top of the widened lane.
// Widening before shifting keeps neighbouring lanes apart.
module vws_lane #(
    parameter int LW   = 8,
    parameter int SH_W = 5
) (
    input  logic [LW-1:0]   elem,
    input  logic            is_uns,
    input  logic [SH_W-1:0] sh,
    output logic [2*LW-1:0] wide
);
    logic [2*LW-1:0] ext;

    // Sign- or zero-extend, then shift inside the double-width lane.
    always_comb begin
        ext  = {{LW{~is_uns & elem[LW-1]}}, elem};
        wide = ext << sh;
    end
endmodule

// File: rtl/vws_datapath.sv
// Lane array: builds the result for all three lane sizes in parallel and
// selects one by the decoded size. Source lane k feeds result lane k.
module vws_datapath
    import vws_pkg::*;
#(
    parameter int SW = SRC_W
) (
    input  logic [SW-1:0]   src,
    input  logic            is_uns,
    input  lane_sz_e        sz,
    input  logic [SH_W-1:0] sh,
    output logic [2*SW-1:0] result
);
    localparam int NSZ = 3;

    logic [NSZ-1:0][2*SW-1:0] by_sz;

    for (genvar s = 0; s < NSZ; s++) begin : g_sz
        localparam int LW = 8 << s;
        localparam int NL = SW / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            vws_lane #(.LW(LW), .SH_W(SH_W)) u_lane (
                .elem   (src[l*LW +: LW]),
                .is_uns (is_uns),
                .sh     (sh),
                .wide   (by_sz[s][l*2*LW +: 2*LW])
            );
        end
    end

    // Pick the lane layout that the decode selected.
    always_comb begin
        unique case (sz)
            LANE_B:  result = by_sz[0];
            LANE_H:  result = by_sz[1];
            LANE_W:  result = by_sz[2];
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/vws_decode.sv
// Instruction decode: checks the fixed opcode bits and finds the lane size
// and shift from the leading one of the 6-bit immediate [21:16].
// Bit 6 of the word takes no part in the decode.
module vws_decode
    import vws_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    logic fixed_ok;
    logic unused_q_bit;

    assign unused_q_bit = insn[6];

    // Check the fixed bits and pick the size by priority on bits [21:19].
    always_comb begin
        fixed_ok = (insn[31:25] == 7'b1111001) && insn[23] &&
                   (insn[11:8] == 4'b1010) && !insn[7] && insn[4];
        dec.is_uns = insn[24];
        dec.vd     = {insn[22], insn[15:12]};
        dec.vm     = {insn[5], insn[3:0]};
        dec.hit    = fixed_ok;
        dec.sz     = LANE_B;
        dec.sh     = '0;
        casez (insn[21:19])
            3'b1??: begin dec.sz = LANE_W; dec.sh = insn[20:16];          end
            3'b01?: begin dec.sz = LANE_H; dec.sh = {1'b0, insn[19:16]};  end
            3'b001: begin dec.sz = LANE_B; dec.sh = {2'b00, insn[18:16]}; end
            default: dec.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vws_widen_shl.sv
// Top of the widening left-shift unit. Decodes the word, runs the lane array,
// checks the register indices and registers every output once.
// Assumes one request per cycle and no back-pressure.
module vws_widen_shl
    import vws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [SRC_W-1:0]  src,
    input  logic              hi_bank_present,
    output logic              out_valid,
    output logic              out_match,
    output logic              out_undef,
    output logic              out_wr_en,
    output logic [IDX_W-1:0]  out_dst,
    output logic [RES_W-1:0]  out_result
);
    dec_t             dec;
    logic             bad_idx;
    logic [RES_W-1:0] dp_result;

    vws_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    vws_datapath #(.SW(SRC_W)) u_dp (
        .src    (src),
        .is_uns (dec.is_uns),
        .sz     (dec.sz),
        .sh     (dec.sh),
        .result (dp_result)
    );

    // Illegal index: odd destination, or upper bank used but absent.
    always_comb begin
        bad_idx = dec.vd[0] ||
                  (!hi_bank_present && (dec.vd[IDX_W-1] || dec.vm[IDX_W-1]));
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_match  <= 1'b0;
            out_undef  <= 1'b0;
            out_wr_en  <= 1'b0;
            out_dst    <= '0;
            out_result <= '0;
        end else begin
            out_valid  <= in_valid;
            out_match  <= in_valid && dec.hit;
            out_undef  <= in_valid && dec.hit && bad_idx;
            out_wr_en  <= in_valid && dec.hit && !bad_idx;
            out_dst    <= dec.vd;
            out_result <= dp_result;
        end
    end
endmodule

// File: rtl/vws_checker.sv
// Protocol and decode properties of the widening left-shift unit.
// It is attached to every instance of the top through the bind below.
module vws_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] insn,
    input logic        hi_bank_present,
    input logic        out_valid,
    input logic        out_match,
    input logic        out_undef,
    input logic        out_wr_en,
    input logic [4:0]  out_dst
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_match && !out_wr_en);
    a_r10_wren_gate: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> out_valid && out_match && !out_undef);
    a_r1_undef_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> out_match);
    a_r8_odd_dst: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_match && out_dst[0] |-> out_undef);
    a_r2_reserved_imm: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (insn[21:19] == 3'b000) |=> !out_match && !out_wr_en);
    a_r9_upper_bank: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !hi_bank_present && (insn[22] || insn[5]) |=> !out_wr_en);
    a_r10_dst_index: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_dst == {$past(insn[22]), $past(insn[15:12])});
endmodule

bind vws_widen_shl vws_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .insn            (insn),
    .hi_bank_present (hi_bank_present),
    .out_valid       (out_valid),
    .out_match       (out_match),
    .out_undef       (out_undef),
    .out_wr_en       (out_wr_en),
    .out_dst         (out_dst)
);

// File: tb/vws_widen_shl_tb.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and
// compares them at the falling edge after the output register loads.
module vws_widen_shl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [63:0]  src = '0;
    logic         hi_bank_present = 1'b1;
    logic         out_valid, out_match, out_undef, out_wr_en;
    logic [4:0]   out_dst;
    logic [127:0] out_result;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic         match;
        logic         undef;
        logic         wren;
        logic [4:0]   dst;
        logic [127:0] res;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    vws_widen_shl u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .insn (insn),
        .src (src), .hi_bank_present (hi_bank_present),
        .out_valid (out_valid), .out_match (out_match), .out_undef (out_undef),
        .out_wr_en (out_wr_en), .out_dst (out_dst), .out_result (out_result)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference: extend each lane, shift, keep 2*esz bits, place in lane k.
    function automatic logic [127:0] model(bit u, int esz, int sh, logic [63:0] s);
        logic [127:0] r = '0;
        logic [63:0]  m = (64'd1 << esz) - 64'd1;
        for (int k = 0; k < 64 / esz; k++) begin
            logic [63:0] e;
            logic [63:0] w;
            e = (s >> (k * esz)) & m;
            if (!u && e[esz-1]) e = e | ~m;
            w = e << sh;
            if (esz < 32) w = w & ((64'd1 << (2 * esz)) - 64'd1);
            r = r | ({64'd0, w} << (k * 2 * esz));
        end
        return r;
    endfunction

    function automatic logic [31:0] mk(bit u, int esz, int sh, logic [4:0] vd,
                                       logic [4:0] vm);
        logic [5:0] imm;
        if (esz == 8)       imm = {3'b001, 3'(sh)};
        else if (esz == 16) imm = {2'b01, 4'(sh)};
        else                imm = {1'b1, 5'(sh)};
        return {7'b1111001, u, 1'b1, vd[4], imm, vd[3:0], 4'b1010,
                1'b0, 1'b0, vm[4], 1'b1, vm[3:0]};
    endfunction

    task automatic push_drive(input logic [31:0] w, input logic [63:0] s,
                              input logic bank, input exp_t e);
        @(negedge clk);
        in_valid = 1'b1; insn = w; src = s; hi_bank_present = bank;
        sb.push_back(e);
    endtask

    // Legal-form request; expectations come from R3..R10.
    task automatic op(input bit u, input int esz, input int sh, input logic [4:0] vd,
                      input logic [4:0] vm, input logic [63:0] s, input logic bank,
                      input string tag);
        exp_t e;
        e.match = 1'b1;
        e.undef = vd[0] | (!bank & (vd[4] | vm[4]));
        e.wren  = !e.undef;
        e.dst   = vd;
        e.res   = model(u, esz, sh, s);
        e.tag   = tag;
        push_drive(mk(u, esz, sh, vd, vm), s, bank, e);
    endtask

    // Word that must not match (R1, R2).
    task automatic nomatch(input logic [31:0] w, input string tag);
        exp_t e;
        e.match = 1'b0; e.undef = 1'b0; e.wren = 1'b0;
        e.dst = '0; e.res = '0; e.tag = tag;
        push_drive(w, 64'hDEAD_BEEF_0123_4567, 1'b1, e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compare each valid output against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected out_valid", 128'(out_valid), 128'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(out_match == e.match, {e.tag, " match"}, 128'(out_match), 128'(e.match));
                chk(out_undef == e.undef, {e.tag, " undef"}, 128'(out_undef), 128'(e.undef));
                chk(out_wr_en == e.wren, {e.tag, " R10 wr_en"}, 128'(out_wr_en), 128'(e.wren));
                if (e.match)
                    chk(out_dst == e.dst, {e.tag, " R10 dst"}, 128'(out_dst), 128'(e.dst));
                if (e.wren)
                    chk(out_result == e.res, {e.tag, " result"}, out_result, e.res);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset clears outputs even with a request pending.
        in_valid = 1'b1;
        insn = mk(1'b1, 8, 1, 5'd2, 5'd3);
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_match && !out_undef && !out_wr_en, "R11 reset state",
            {124'd0, out_valid, out_match, out_undef, out_wr_en}, 128'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        chk(!out_valid, "R11 idle after reset", 128'(out_valid), 128'd0);

        // R3 R4 R5 R7: plain widening of each size, both signs.
        op(1'b0, 8,  0, 5'd0, 5'd1, 64'h80FF_7F01_8C3A_00FE, 1'b1, "R5 R4 s8 sh0");
        op(1'b1, 8,  0, 5'd2, 5'd1, 64'h80FF_7F01_8C3A_00FE, 1'b1, "R5 R4 u8 sh0");
        op(1'b0, 16, 0, 5'd4, 5'd1, 64'h8001_7FFF_C000_1234, 1'b1, "R5 R7 s16 sh0");
        op(1'b1, 32, 0, 5'd6, 5'd1, 64'h8000_0001_FFFF_FFFE, 1'b1, "R5 R7 u32 sh0");
        op(1'b0, 32, 0, 5'd6, 5'd1, 64'h8000_0001_7FFF_FFFE, 1'b1, "R5 R7 s32 sh0");
        // R6: all-ones lanes with the largest shift per size.
        op(1'b1, 8,  7,  5'd8,  5'd2, '1, 1'b1, "R6 u8 sh7");
        op(1'b0, 8,  7,  5'd8,  5'd2, '1, 1'b1, "R6 s8 sh7");
        op(1'b1, 16, 15, 5'd10, 5'd2, '1, 1'b1, "R6 u16 sh15");
        op(1'b0, 16, 15, 5'd10, 5'd2, '1, 1'b1, "R6 s16 sh15");
        op(1'b1, 32, 31, 5'd12, 5'd2, '1, 1'b1, "R6 u32 sh31");
        op(1'b0, 32, 31, 5'd12, 5'd2, '1, 1'b1, "R6 s32 sh31");
        idle(2);
        // R3: middle shifts with varied data, back to back.
        for (int i = 0; i < 12; i++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            op(i[0], 8 << (i % 3), (i * 5) % (8 << (i % 3)), 5'(2 * (i % 8)),
               5'(i), d, 1'b1, "R3 R4 R7 mixed");
        end
        // R8: odd destination.
        op(1'b1, 16, 3, 5'd5, 5'd0, 64'h1234_5678_9ABC_DEF0, 1'b1, "R8 odd vd");
        // R9: upper-bank indices without and with the bank.
        op(1'b0, 8, 2, 5'd18, 5'd0,  64'h0102_0304_0506_0708, 1'b0, "R9 vd hi absent");
        op(1'b0, 8, 2, 5'd2,  5'd17, 64'h0102_0304_0506_0708, 1'b0, "R9 vm hi absent");
        op(1'b0, 8, 2, 5'd18, 5'd17, 64'h0102_0304_0506_0708, 1'b1, "R9 hi present");
        // R2: size field 000 with correct fixed bits.
        nomatch(mk(1'b1, 8, 3, 5'd2, 5'd1) & ~32'h0038_0000, "R2 imm000");
        // R1: one fixed bit flipped at a time.
        nomatch(mk(1'b1, 16, 3, 5'd2, 5'd1) & ~32'h0000_0010, "R1 bit4 clear");
        nomatch(mk(1'b1, 16, 3, 5'd2, 5'd1) | 32'h0000_0080, "R1 bit7 set");
        nomatch(mk(1'b1, 16, 3, 5'd2, 5'd1) ^ 32'h0000_0100, "R1 field 11:8");
        nomatch(mk(1'b1, 16, 3, 5'd2, 5'd1) & ~32'h0080_0000, "R1 bit23 clear");
        nomatch(mk(1'b1, 16, 3, 5'd2, 5'd1) ^ 32'h0200_0000, "R1 top bits");
        idle(3);
        chk(sb.size() == 0, "R11 all results seen", 128'(sb.size()), 128'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule